// File: doc/BRIEF.md
# Serial Command Port with Converter Register Bank

This block is the device-side serial port of a measurement converter. A host talks to it over a four-wire serial bus: an active-low select, a serial clock, a data line into the device and a data line out of it. Every transaction begins with an 8-bit command byte. The top bit of the byte routes it. With the top bit clear, the byte is a register access: 32-bit words are written into, or read out of, one of four register kinds. These are the per-channel offset registers, the per-channel gain registers, a single configuration register, and the channel-setup registers, each of which packs two 16-bit setups. With the top bit set, the byte starts a conversion or a calibration on one of the eight setups.

Operations are carried out by an external engine through a request/done handshake that returns a 24-bit sample. While an operation is in flight, the data-out line is held high. It drops low when the engine reports completion. For a conversion, the host then clocks eight flag-clearing bits and reads a 32-bit result word, and the port goes back to waiting for commands. The serial lines are oversampled by the system clock through two-stage synchronisers. Instead of a bidirectional pin, the data-out line is given as a value plus an output enable.

Top module: `serial_cmd_port`

## Requirements
- R1: After reset, opReq is low, sdoEn is low while csN is high, and the registers hold their defaults: offsets 0, gains 32'h0100_0000, configuration 0, setups 0.
- R2: sdi is taken on each rising sclk edge, MSB first. sdo moves only after a falling sclk edge. sdoEn follows the inverse of csN. Raising csN clears the bit counter, so a partly sent byte is dropped.
- R3: A command byte with bit 7 = 0 is a register access. Its fields are: bit 6 all-registers, bits 5:4 index, bit 3 read (1) or write (0), and bits 2:0 kind (001 offset, 010 gain, 011 configuration, 101 setup). A write takes the next 32 bits. A read presents its MSB after the command's 8th falling edge and then shifts 32 bits. Any other kind code has no data phase.
- R4: With bit 6 set, the access repeats for indices 0, 1, 2, 3 in that order for offset, gain and setup, and covers a single word for the configuration register.
- R5: A command byte with bit 7 = 1 raises opReq, with opCode = bits 2:0 and pointer = bits 5:3. The pointer's bits 2:1 pick the setup register and its bit 0 picks the half (0 selects bits 31:16, 1 selects bits 15:0). That half drives opSetup.
- R6: While opReq is high, sdo is high. One cycle after opDone is sampled, opReq is low and sdo is low.
- R7: While an operation is pending, complete command bytes have no effect, except 8'hFF. That byte drops opReq and returns the port to command mode.
- R8: When opCode was 000 (conversion), the host sends 8 flag-clearing clocks after completion and then reads 32 bits: {sample, 6'b0, channel}, where channel is bits 15:14 of the selected setup. The port then accepts commands again. Any other opCode (calibration) returns the port straight to command mode, with sdo held low.
- R9: Writing the configuration register with bit 29 set loads every register with its default and leaves bit 29 reading 1. Writing bit 29 back to 0 clears it.
- R10: powerSave mirrors configuration bit 31 and rateSel mirrors configuration bit 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial data out, also the completion flag |
| sdoEn | output | 1 | Output enable for sdo |
| opReq | output | 1 | Operation request, held until done or stop |
| opCode | output | 3 | Operation code from the start command |
| opSetup | output | 16 | Setup selected by the start command |
| opDone | input | 1 | One-cycle completion pulse from the engine |
| opSample | input | 24 | Sample delivered with opDone |
| powerSave | output | 1 | Configuration bit 31 |
| rateSel | output | 1 | Configuration bit 19 |

## Verification
A bit counter that is out of step shows up as a wrong word on the very next read-back, because every field after the command byte is then misaligned. For that reason each write is confirmed by reading the same register back through the serial port. A wrong state during an operation is visible at sdo within a few system cycles: sdo is low while the operation should be pending, it stays high after opDone, or a byte that should have been ignored changes a register. The bench reads the affected register back afterwards to catch that last case. A wrong setup pointer or a wrong channel field is caught at opSetup as soon as the request rises, and again in the low byte of the result word.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int WORD_W   = 32;
  localparam int SAMPLE_W = 24;
  localparam int SETUP_W  = 16;
  localparam int CH_COUNT = 4;
  localparam int IDX_W    = $clog2(CH_COUNT);
  localparam int PTR_W    = IDX_W + 1;
  localparam int CNT_W    = $clog2(WORD_W);
  localparam int RS_BIT   = 29;
  localparam int PS_BIT   = 31;
  localparam int FR_BIT   = 19;

  localparam logic [2:0] T_OFFSET = 3'b001;
  localparam logic [2:0] T_GAIN   = 3'b010;
  localparam logic [2:0] T_CFG    = 3'b011;
  localparam logic [2:0] T_SETUP  = 3'b101;

  localparam logic [WORD_W-1:0] GAIN_DEF = 32'h0100_0000;
  localparam logic [WORD_W-1:0] CFG_DEF  = '0;
  localparam logic [7:0]        STOP_CMD = 8'hFF;

  typedef enum logic [2:0] {ST_CMD, ST_WR, ST_RD, ST_PEND, ST_FLAG} state_t;

  typedef struct packed {
    logic             shiftIn;
    logic             writeReg;
    logic             loadOut;
    logic             shiftOut;
    logic             loadResult;
    logic             clearSdo;
    logic [2:0]       wrType;
    logic [IDX_W-1:0] wrIdx;
    logic [2:0]       ldType;
    logic [IDX_W-1:0] ldIdx;
    logic [PTR_W-1:0] setupPtr;
  } strobe_t;
endpackage

// File: rtl/scp_datapath.sv
module scp_datapath import scp_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                sdiS,
  input  logic [SAMPLE_W-1:0] opSample,
  output logic [6:0]          cmdHead,
  output logic                sdoBit,
  output logic [SETUP_W-1:0]  opSetup,
  output logic                powerSave,
  output logic                rateSel
);
  logic [WORD_W-1:0] inShift, outShift, wordIn, readVal, cfgR;
  logic [WORD_W-1:0] offsetR [CH_COUNT];
  logic [WORD_W-1:0] gainR   [CH_COUNT];
  logic [WORD_W-1:0] setupR  [CH_COUNT];
  logic [WORD_W-1:0] resultWord;

  assign wordIn  = {inShift[WORD_W-2:0], sdiS};
  assign cmdHead = inShift[6:0];
  assign opSetup = strb.setupPtr[0] ? setupR[strb.setupPtr[PTR_W-1:1]][SETUP_W-1:0]
                                    : setupR[strb.setupPtr[PTR_W-1:1]][WORD_W-1:SETUP_W];
  assign resultWord = {opSample, {(WORD_W-SAMPLE_W-2){1'b0}}, opSetup[SETUP_W-1 -: 2]};
  assign powerSave = cfgR[PS_BIT];
  assign rateSel   = cfgR[FR_BIT];

  always_comb begin
    case (strb.ldType)
      T_OFFSET: readVal = offsetR[strb.ldIdx];
      T_GAIN:   readVal = gainR[strb.ldIdx];
      T_SETUP:  readVal = setupR[strb.ldIdx];
      default:  readVal = cfgR;
    endcase
  end

  // register bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgR <= CFG_DEF;
      for (int i = 0; i < CH_COUNT; i++) begin
        offsetR[i] <= '0;
        gainR[i]   <= GAIN_DEF;
        setupR[i]  <= '0;
      end
    end else if (strb.writeReg) begin
      case (strb.wrType)
        T_OFFSET: offsetR[strb.wrIdx] <= wordIn;
        T_GAIN:   gainR[strb.wrIdx]   <= wordIn;
        T_SETUP:  setupR[strb.wrIdx]  <= wordIn;
        default: begin
          if (wordIn[RS_BIT]) begin
            cfgR <= CFG_DEF | (WORD_W'(1) << RS_BIT);
            for (int i = 0; i < CH_COUNT; i++) begin
              offsetR[i] <= '0;
              gainR[i]   <= GAIN_DEF;
              setupR[i]  <= '0;
            end
          end else begin
            cfgR <= wordIn;
          end
        end
      endcase
    end
  end

  // shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      outShift <= '0;
      sdoBit   <= 1'b0;
    end else begin
      if (strb.shiftIn) inShift <= wordIn;
      if (strb.loadResult)    outShift <= resultWord;
      else if (strb.loadOut)  outShift <= readVal;
      else if (strb.shiftOut) outShift <= {outShift[WORD_W-2:0], 1'b0};
      if (strb.clearSdo)      sdoBit <= 1'b0;
      else if (strb.shiftOut) sdoBit <= outShift[WORD_W-1];
    end
  end

  // R9: a configuration write with the reset bit restores defaults
  a_r9_reset_defaults: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeReg && strb.wrType == T_CFG && wordIn[RS_BIT])
    |=> (cfgR[RS_BIT] && gainR[0] == GAIN_DEF && offsetR[0] == '0));

  // R6: completion forces the data-out flag low
  a_r6_flag_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearSdo |=> !sdoBit);
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl import scp_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [6:0] cmdHead,
  input  logic       sdoBit,
  input  logic       opDone,
  output strobe_t    strb,
  output logic       sdiS,
  output logic       sdo,
  output logic       sdoEn,
  output logic       opReq,
  output logic [2:0] opCode
);
  logic [1:0] csSync, sdiSync;
  logic [2:0] sclkSync;
  logic       csS, rise, fall, cntClr;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] cmdByte;
  state_t     state, stateN;
  logic [2:0] regType, typeN, codeN;
  logic [IDX_W-1:0] regIdx, idxN;
  logic [PTR_W-1:0] setupPtr, ptrN;
  logic       allMode, allN, reqN, more;

  function automatic logic [IDX_W-1:0] lastIdx(input logic [2:0] t);
    return (t == T_CFG) ? '0 : IDX_W'(CH_COUNT - 1);
  endfunction

  function automatic logic typeValid(input logic [2:0] t);
    return (t == T_OFFSET) || (t == T_GAIN) || (t == T_CFG) || (t == T_SETUP);
  endfunction

  assign csS     = csSync[1];
  assign sdiS    = sdiSync[1];
  assign rise    = !csS && sclkSync[1] && !sclkSync[2];
  assign fall    = !csS && !sclkSync[1] && sclkSync[2];
  assign cmdByte = {cmdHead, sdiS};
  assign more    = allMode && (regIdx != lastIdx(regType));
  assign sdoEn   = !csS;
  assign sdo     = (state == ST_PEND) ? 1'b1 : sdoBit;

  always_comb begin
    stateN = state; typeN = regType; idxN = regIdx; allN = allMode;
    ptrN = setupPtr; codeN = opCode; reqN = opReq; cntClr = 1'b0;
    strb = '0;
    strb.shiftIn  = rise;
    strb.wrType   = regType;
    strb.wrIdx    = regIdx;
    strb.ldType   = regType;
    strb.ldIdx    = regIdx;
    strb.setupPtr = setupPtr;
    case (state)
      ST_CMD: if (rise && bitCnt == CNT_W'(7)) begin
        cntClr = 1'b1;
        if (cmdByte[7]) begin
          stateN = ST_PEND; reqN = 1'b1;
          ptrN = cmdByte[5:3]; codeN = cmdByte[2:0];
        end else if (typeValid(cmdByte[2:0])) begin
          typeN = cmdByte[2:0];
          allN  = cmdByte[6];
          idxN  = (cmdByte[6] || typeN == T_CFG) ? '0 : cmdByte[5:4];
          if (cmdByte[3]) begin
            stateN = ST_RD; strb.loadOut = 1'b1;
            strb.ldType = typeN; strb.ldIdx = idxN;
          end else begin
            stateN = ST_WR;
          end
        end
      end
      ST_WR: if (rise && bitCnt == CNT_W'(WORD_W - 1)) begin
        cntClr = 1'b1; strb.writeReg = 1'b1;
        if (more) idxN = regIdx + IDX_W'(1);
        else      stateN = ST_CMD;
      end
      ST_RD: begin
        strb.shiftOut = fall;
        if (rise && bitCnt == CNT_W'(WORD_W - 1)) begin
          cntClr = 1'b1;
          if (more) begin
            idxN = regIdx + IDX_W'(1);
            strb.loadOut = 1'b1; strb.ldIdx = idxN;
          end else begin
            stateN = ST_CMD;
          end
        end
      end
      ST_PEND: begin
        if (opDone) begin
          reqN = 1'b0; cntClr = 1'b1; strb.clearSdo = 1'b1;
          if (opCode == 3'b000) begin
            strb.loadResult = 1'b1; stateN = ST_FLAG;
          end else begin
            stateN = ST_CMD;
          end
        end else if (rise && bitCnt == CNT_W'(7)) begin
          cntClr = 1'b1;
          if (cmdByte == STOP_CMD) begin
            reqN = 1'b0; stateN = ST_CMD;
          end
        end
      end
      ST_FLAG: if (rise && bitCnt == CNT_W'(7)) begin
        cntClr = 1'b1; allN = 1'b0; stateN = ST_RD;
      end
      default: stateN = ST_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= 2'b11; sdiSync <= '0; sclkSync <= '0;
      bitCnt <= '0; state <= ST_CMD; regType <= T_CFG; regIdx <= '0;
      allMode <= 1'b0; setupPtr <= '0; opCode <= '0; opReq <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sdiSync  <= {sdiSync[0], sdi};
      sclkSync <= {sclkSync[1:0], sclk};
      if (csS || cntClr) bitCnt <= '0;
      else if (rise)     bitCnt <= bitCnt + CNT_W'(1);
      state <= stateN; regType <= typeN; regIdx <= idxN; allMode <= allN;
      setupPtr <= ptrN; opCode <= codeN; opReq <= reqN;
    end
  end

  // R6: completion releases the request on the next cycle
  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && opDone) |=> !opReq);

  // R7: bytes sent while pending leave the operation code untouched
  a_r7_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !opDone) |=> $stable(opCode));

  // R3: command decode happens within an 8-bit frame
  a_r3_cmd_frame: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD) |-> (bitCnt < CNT_W'(8)));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port import scp_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  output logic                sdo,
  output logic                sdoEn,
  output logic                opReq,
  output logic [2:0]          opCode,
  output logic [SETUP_W-1:0]  opSetup,
  input  logic                opDone,
  input  logic [SAMPLE_W-1:0] opSample,
  output logic                powerSave,
  output logic                rateSel
);
  strobe_t    strb;
  logic       sdiS, sdoBit;
  logic [6:0] cmdHead;

  scp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .cmdHead(cmdHead), .sdoBit(sdoBit), .opDone(opDone),
    .strb(strb), .sdiS(sdiS), .sdo(sdo), .sdoEn(sdoEn),
    .opReq(opReq), .opCode(opCode)
  );

  scp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiS(sdiS), .opSample(opSample),
    .cmdHead(cmdHead), .sdoBit(sdoBit), .opSetup(opSetup),
    .powerSave(powerSave), .rateSel(rateSel)
  );

  // R6: data-out stays high for as long as an operation is requested
  a_r6_pending_high: assert property (@(posedge clk) disable iff (!rstN)
    opReq |-> sdo);
endmodule

// File: tb/serial_cmd_port_tb.sv
module serial_cmd_port_tb;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic opDone = 1'b0;
  logic [23:0] opSample = '0;
  logic sdo, sdoEn, opReq, powerSave, rateSel;
  logic [2:0] opCode;
  logic [15:0] opSetup;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  serial_cmd_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .opReq(opReq), .opCode(opCode),
    .opSetup(opSetup), .opDone(opDone), .opSample(opSample),
    .powerSave(powerSave), .rateSel(rateSel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clockBit(input logic b, output logic r);
    sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) clockBit(v[i], r);
  endtask

  task automatic sendWord(input logic [31:0] v);
    logic r;
    for (int i = 31; i >= 0; i--) clockBit(v[i], r);
  endtask

  // driver side: queue what the next read must return
  task automatic expectWord(input logic [31:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // monitor side: collect a word and compare with the queue head
  task automatic readCheck();
    logic [31:0] w;
    logic r;
    for (int i = 31; i >= 0; i--) begin
      clockBit(1'b0, r);
      w[i] = r;
    end
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty actual=%h expected=none", w);
    end else begin
      check(tagQ.pop_front(), w, expQ.pop_front());
    end
  endtask

  task automatic pulseDone(input logic [23:0] s);
    @(negedge clk);
    opSample = s; opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 sdoEn idle", 32'(sdoEn), 32'd0);
    check("R1 opReq idle", 32'(opReq), 32'd0);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 sdoEn selected", 32'(sdoEn), 32'd1);

    sendByte(8'h1A); expectWord(32'h0100_0000, "R1 gain1 default"); readCheck();

    sendByte(8'h21); sendWord(32'h1234_5678);
    sendByte(8'h29); expectWord(32'h1234_5678, "R3 offset2 readback"); readCheck();

    // R2: a partial byte dropped by deselect
    sendByte(8'hFF >> 5);
    begin logic r; clockBit(1'b1, r); clockBit(1'b1, r); clockBit(1'b1, r); end
    csN = 1'b1; repeat (4) @(negedge clk);
    check("R2 sdoEn deselected", 32'(sdoEn), 32'd0);
    csN = 1'b0; repeat (4) @(negedge clk);
    sendByte(8'h29); expectWord(32'h1234_5678, "R2 realign after cs"); readCheck();

    // R3: undefined kind code has no data phase
    sendByte(8'h00);
    sendByte(8'h29); expectWord(32'h1234_5678, "R3 undefined kind"); readCheck();

    // R4: all-offsets write and read in index order
    sendByte(8'h41);
    for (int i = 0; i < 4; i++) sendWord(32'h1111_0000 + 32'(i));
    sendByte(8'h49);
    for (int i = 0; i < 4; i++) expectWord(32'h1111_0000 + 32'(i), "R4 all offsets");
    for (int i = 0; i < 4; i++) readCheck();

    sendByte(8'h03); sendWord(32'h8008_0000);
    check("R10 powerSave", 32'(powerSave), 32'd1);
    check("R10 rateSel", 32'(rateSel), 32'd1);
    sendByte(8'h0B); expectWord(32'h8008_0000, "R3 config readback"); readCheck();

    sendByte(8'h15); sendWord(32'h4123_C456);

    // conversion on pointer 3: setup register 1, low half
    sendByte(8'h98);
    repeat (4) @(negedge clk);
    check("R5 opReq", 32'(opReq), 32'd1);
    check("R5 opSetup low half", 32'(opSetup), 32'h0000_C456);
    check("R5 opCode", 32'(opCode), 32'd0);
    check("R6 sdo pending", 32'(sdo), 32'd1);
    sendByte(8'h21);
    check("R7 ignored byte keeps request", 32'(opReq), 32'd1);
    pulseDone(24'hABCDEF);
    check("R6 sdo after done", 32'(sdo), 32'd0);
    check("R6 opReq after done", 32'(opReq), 32'd0);
    sendByte(8'h00);
    expectWord(32'hABCD_EF03, "R8 conversion word"); readCheck();
    sendByte(8'h29); expectWord(32'h1111_0002, "R7 pending write ignored"); readCheck();

    // calibration on pointer 2: setup register 1, high half
    sendByte(8'h92);
    repeat (4) @(negedge clk);
    check("R5 opSetup high half", 32'(opSetup), 32'h0000_4123);
    check("R5 opCode cal", 32'(opCode), 32'd2);
    pulseDone(24'h000001);
    check("R8 cal sdo low", 32'(sdo), 32'd0);
    sendByte(8'h19); expectWord(32'h1111_0001, "R8 command mode after cal"); readCheck();

    // stop while pending
    sendByte(8'h98);
    repeat (4) @(negedge clk);
    check("R7 request before stop", 32'(opReq), 32'd1);
    sendByte(8'hFF);
    repeat (4) @(negedge clk);
    check("R7 stop drops request", 32'(opReq), 32'd0);
    sendByte(8'h0B); expectWord(32'h8008_0000, "R7 command mode after stop"); readCheck();

    // reset bit
    sendByte(8'h03); sendWord(32'h2000_0000);
    sendByte(8'h0B); expectWord(32'h2000_0000, "R9 reset bit held"); readCheck();
    sendByte(8'h09); expectWord(32'h0000_0000, "R9 offset0 default"); readCheck();
    sendByte(8'h1D); expectWord(32'h0000_0000, "R9 setup1 default"); readCheck();
    check("R9 powerSave default", 32'(powerSave), 32'd0);
    sendByte(8'h03); sendWord(32'h0000_0000);
    sendByte(8'h0B); expectWord(32'h0000_0000, "R9 reset bit cleared"); readCheck();

    csN = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 sdoEn final", 32'(sdoEn), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule